// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns words taken from an external transmit queue into asynchronous NRZ frames on a single serial line. When the queue holds a word and the block is idle, it pops the word and captures the line settings at that moment. It then waits an optional number of clock cycles and sends the frame: a start bit, 1 to 32 data bits with the least significant bit first, an optional odd or even parity bit, and one, one and a half or two stop bits.

Bit timing comes from an internal oversampling tick. The tick fires once every `baud_div` clocks, and each bit lasts 16 ticks, so the bit rate is the clock frequency divided by 16 × divisor. An output-enable pin is high for the whole frame so that a half-duplex line driver can be switched on. A one-cycle done pulse marks the end of the last frame when no further word is waiting. The queue storage and register access sit outside this block.

Top module: `serial_tx`

## Requirements
- R1: After reset, and whenever the queue is empty and no frame is in flight, `txd` is 1, `tx_oe` is 0, `tx_done` is 0 and `q_pop` is 0.
- R2: A frame is a start bit (0), then the data bits least significant first, then the parity bit if enabled, then the stop level (1). Each start, data and parity bit lasts 16 × `baud_div` clocks, and a `baud_div` of 0 behaves as 1.
- R3: The number of data bits equals `char_len` for values 1 to 32. A `char_len` of 0 sends 1 bit, and values above 32 send 32 bits.
- R4: `parity_mode` 0 or 3 sends no parity bit. With 1 (odd), the parity bit makes the count of ones over data and parity odd. With 2 (even), it makes that count even.
- R5: `stop_mode` 00 gives a stop phase of 16 ticks, 01 gives 24 ticks (1.5 bits), and 10 or 11 gives 32 ticks.
- R6: After a pop, the line stays at 1 with `tx_oe` at 0 for exactly `tx_delay` clock cycles before the start bit. A delay of 0 starts the start bit in the cycle right after the pop.
- R7: `tx_oe` is 1 from the first cycle of the start bit through the last cycle of the stop phase, and 0 in the cycle after.
- R8: In the cycle after the stop phase ends, `tx_done` is 1 for exactly one cycle if the queue is empty at that moment. If the queue is not empty, `tx_done` stays 0 and the next word is popped in that same cycle.
- R9: Divisor, character size, parity, stop and delay settings are captured at the pop. Changing them during a frame does not alter that frame.
- R10: `q_pop` is a one-cycle strobe, raised only while the block is idle and `q_empty` is 0. `q_data` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 16 | Clocks per oversample tick (0 treated as 1) |
| char_len | input | 6 | Data bits per character |
| parity_mode | input | 2 | 0 none, 1 odd, 2 even, 3 none |
| stop_mode | input | 2 | 00 one, 01 one and a half, 10/11 two stop bits |
| tx_delay | input | 16 | Idle clocks inserted before each start bit |
| q_empty | input | 1 | Transmit queue holds no word |
| q_data | input | 32 | Word at the head of the queue |
| q_pop | output | 1 | Removes the head word from the queue |
| txd | output | 1 | Serial data line, idle high |
| tx_oe | output | 1 | Line driver enable, high during a frame |
| tx_done | output | 1 | One-cycle pulse after the last frame |

## Verification
Random frames vary the word, character size, parity, stop mode, divisor and delay together. Sampling at every bit centre tells bit order and bit count apart from parity polarity, and sampling in the last stop cycle and the cycle after it separates the three stop lengths. Directed frames cover the boundary cases: a divisor of 0 and a character size of 0, a size above 32, the spare parity and stop codes, and a delay of one cycle. Two queued words sent back to back show the done pulse being suppressed, and a frame whose settings change mid-flight shows that the captured settings are kept.

// File: rtl/serial_tx_pkg.sv
// Shared constants and state type for the serial transmitter.
// Assumes a 16x oversampling scheme; codes match the control inputs.
package serial_tx_pkg;

    localparam int OVS_TICKS = 16;

    localparam logic [1:0] PAR_CODE_ODD  = 2'd1;
    localparam logic [1:0] PAR_CODE_EVEN = 2'd2;

    localparam logic [1:0] STOP_CODE_ONE  = 2'b00;
    localparam logic [1:0] STOP_CODE_HALF = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/sx_tick_gen.sv
// Oversample tick generator: pulses 'tick' once every 'div' clocks while
// 'en' is high (div of 0 acts as 1). Assumes 'div' is stable while enabled;
// the count restarts from zero whenever 'en' drops.
module sx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    // Terminal count of the divider, treating zero as one.
    always_comb last = (div == '0) ? '0 : div - DIV_W'(1);

    assign tick = en && (cnt_q == last);

    // Divider counter, cleared when disabled or on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!en || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + DIV_W'(1);
    end

    // R2
    tick_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);

    // R2
    tick_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);

endmodule

// File: rtl/sx_shifter.sv
// Data shift register with running parity. 'load' captures a word; each
// 'shift' drops bit 0 and folds it into 'par_acc', so after the last data
// bit 'par_acc' is the XOR of exactly the bits that went out.
module sx_shifter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              cur_bit,
    output logic              par_acc
);

    logic [DATA_W-1:0] sr_q;
    logic              par_q;

    // Load or shift the word, updating the running parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sr_q  <= load_data;
            par_q <= 1'b0;
        end else if (shift) begin
            sr_q  <= sr_q >> 1;
            par_q <= par_q ^ sr_q[0];
        end
    end

    assign cur_bit = sr_q[0];
    assign par_acc = par_q;

    // R10
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_bit == $past(load_data[0]) && !par_acc);

endmodule

// File: rtl/sx_seq.sv
// Frame sequencer: pops a word when idle, captures the line settings,
// runs the delay, then steps through start, data, parity and stop phases
// by counting oversample ticks. Assumes 'q_data' is valid while 'q_empty'
// is low and that the queue removes its head on 'q_pop'.
module sx_seq
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int DLY_W  = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [LEN_W-1:0] char_len,
    input  logic [1:0]       parity_mode,
    input  logic [1:0]       stop_mode,
    input  logic [DLY_W-1:0] tx_delay,
    input  logic             q_empty,
    input  logic             tick,
    input  logic             cur_bit,
    input  logic             par_acc,
    output logic             q_pop,
    output logic             shift,
    output logic             tick_en,
    output logic [DIV_W-1:0] div_q,
    output logic             txd,
    output logic             tx_oe,
    output logic             tx_done
);

    localparam int SUB_W = $clog2(2 * OVS_TICKS);

    tx_state_e        state_q;
    logic [LEN_W-1:0] len_q, len_norm, bit_idx_q;
    logic [1:0]       par_q, stop_q;
    logic [DLY_W-1:0] dly_q;
    logic [SUB_W-1:0] sub_q, phase_last, stop_last;
    logic             par_on, bit_end, done_q;

    // Clamp the requested character size into 1..DATA_W.
    always_comb begin
        if (char_len == '0)                  len_norm = LEN_W'(1);
        else if (char_len > LEN_W'(DATA_W))  len_norm = LEN_W'(DATA_W);
        else                                 len_norm = char_len;
    end

    // Last tick index of the stop phase for the captured stop mode.
    always_comb begin
        case (stop_q)
            STOP_CODE_ONE:  stop_last = SUB_W'(OVS_TICKS - 1);
            STOP_CODE_HALF: stop_last = SUB_W'(OVS_TICKS + OVS_TICKS / 2 - 1);
            default:        stop_last = SUB_W'(2 * OVS_TICKS - 1);
        endcase
    end

    assign par_on     = (par_q == PAR_CODE_ODD) || (par_q == PAR_CODE_EVEN);
    assign phase_last = (state_q == ST_STOP) ? stop_last : SUB_W'(OVS_TICKS - 1);
    assign tick_en    = (state_q != ST_IDLE) && (state_q != ST_WAIT);
    assign bit_end    = tick && (sub_q == phase_last);
    assign q_pop      = (state_q == ST_IDLE) && !q_empty;
    assign shift      = (state_q == ST_DATA) && bit_end;
    assign tx_oe      = tick_en;
    assign tx_done    = done_q;

    // Line level for the current phase.
    always_comb begin
        case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = cur_bit;
            ST_PAR:   txd = (par_q == PAR_CODE_ODD) ? ~par_acc : par_acc;
            default:  txd = 1'b1;
        endcase
    end

    // Tick counter inside the current bit or stop phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sub_q <= '0;
        else if (!tick_en || bit_end) sub_q <= '0;
        else if (tick)              sub_q <= sub_q + SUB_W'(1);
    end

    // Done strobe after the stop phase when nothing is queued.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_STOP) && bit_end && q_empty;
    end

    // Phase sequencing and capture of the line settings at the pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            len_q     <= LEN_W'(1);
            par_q     <= '0;
            stop_q    <= '0;
            dly_q     <= '0;
            div_q     <= DIV_W'(1);
            bit_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (q_pop) begin
                    len_q   <= len_norm;
                    par_q   <= parity_mode;
                    stop_q  <= stop_mode;
                    div_q   <= baud_div;
                    dly_q   <= tx_delay;
                    state_q <= (tx_delay != '0) ? ST_WAIT : ST_START;
                end
                ST_WAIT: begin
                    if (dly_q == DLY_W'(1)) state_q <= ST_START;
                    dly_q <= dly_q - DLY_W'(1);
                end
                ST_START: if (bit_end) begin
                    bit_idx_q <= '0;
                    state_q   <= ST_DATA;
                end
                ST_DATA: if (bit_end) begin
                    bit_idx_q <= bit_idx_q + LEN_W'(1);
                    if (bit_idx_q == len_q - LEN_W'(1))
                        state_q <= par_on ? ST_PAR : ST_STOP;
                end
                ST_PAR:  if (bit_end) state_q <= ST_STOP;
                ST_STOP: if (bit_end) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !q_empty && !tx_oe);

    // R8
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(tx_oe) && !tx_oe);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R7
    oe_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> !txd);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> txd);

    // R9
    div_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe && $past(tx_oe) |-> $stable(div_q));

endmodule

// File: rtl/serial_tx.sv
// Top of the configurable serial transmitter: ties the tick generator,
// the data shifter and the frame sequencer together. Assumes an external
// queue that presents its head word on 'q_data' and removes it on 'q_pop'.
module serial_tx #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int DLY_W  = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [LEN_W-1:0]  char_len,
    input  logic [1:0]        parity_mode,
    input  logic [1:0]        stop_mode,
    input  logic [DLY_W-1:0]  tx_delay,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    output logic              q_pop,
    output logic              txd,
    output logic              tx_oe,
    output logic              tx_done
);

    logic             tick, tick_en, shift, cur_bit, par_acc;
    logic [DIV_W-1:0] div_q;

    sx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .div  (div_q),
        .tick (tick)
    );

    sx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q_pop),
        .load_data(q_data),
        .shift    (shift),
        .cur_bit  (cur_bit),
        .par_acc  (par_acc)
    );

    sx_seq #(
        .DATA_W(DATA_W),
        .DIV_W (DIV_W),
        .DLY_W (DLY_W),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_div   (baud_div),
        .char_len   (char_len),
        .parity_mode(parity_mode),
        .stop_mode  (stop_mode),
        .tx_delay   (tx_delay),
        .q_empty    (q_empty),
        .tick       (tick),
        .cur_bit    (cur_bit),
        .par_acc    (par_acc),
        .q_pop      (q_pop),
        .shift      (shift),
        .tick_en    (tick_en),
        .div_q      (div_q),
        .txd        (txd),
        .tx_oe      (tx_oe),
        .tx_done    (tx_done)
    );

endmodule

// File: tb/serial_tx_tb.sv
// Self-checking bench: a small queue model feeds words, and each frame is
// checked at bit centres and at its exact edges against bench-computed values.
module serial_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd5;
    logic [5:0]  char_len = 6'd8;
    logic [1:0]  parity_mode = 2'd0;
    logic [1:0]  stop_mode = 2'd0;
    logic [15:0] tx_delay = 16'd0;
    logic        q_empty;
    logic [31:0] q_data;
    logic        q_pop, txd, tx_oe, tx_done;

    logic [31:0] qmem [64];
    logic [5:0]  wr_ptr = '0;
    logic [5:0]  rd_ptr = '0;
    int          n_vec = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    assign q_empty = (rd_ptr == wr_ptr);
    assign q_data  = qmem[rd_ptr];

    always @(posedge clk) if (q_pop) rd_ptr <= rd_ptr + 6'd1;

    serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .char_len(char_len),
        .parity_mode(parity_mode), .stop_mode(stop_mode), .tx_delay(tx_delay),
        .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop), .txd(txd),
        .tx_oe(tx_oe), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic step_to(inout int k, input int t);
        while (k < t) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic push(input logic [31:0] w);
        qmem[wr_ptr] = w;
        wr_ptr = wr_ptr + 6'd1;
    endtask

    function automatic int eff_len(input int len);
        return (len == 0) ? 1 : ((len > 32) ? 32 : len);
    endfunction

    function automatic int stop_ticks(input int stop);
        return (stop == 0) ? 16 : ((stop == 1) ? 24 : 32);
    endfunction

    function automatic int par_bit(input logic [31:0] w, input int n, input int par);
        logic [31:0] mask;
        int ones;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        ones = $countones(w & mask);
        return (par == 1) ? ((ones & 1) ^ 1) : (ones & 1);
    endfunction

    // Check one frame; starts at the negedge where q_pop is seen.
    task automatic check_frame(input logic [31:0] w, input int len, input int par,
                               input int stop, input int div, input int dly,
                               input bit exp_done, input bit scramble);
        int k, n, de, b, p, s0, kend;
        n  = eff_len(len);
        de = (div == 0) ? 1 : div;
        b  = 16 * de;
        p  = (par == 1 || par == 2) ? 1 : 0;
        while (!q_pop) @(negedge clk);
        k = -1;
        chk(q_pop && !tx_oe, "R10 pop while idle", q_pop, 1);
        if (dly > 0) begin
            step_to(k, dly - 1);
            chk(txd && !tx_oe, "R6 delay line idle", {txd, tx_oe}, 2);
        end
        step_to(k, dly);
        chk(!txd && tx_oe, "R7 start edge", {txd, tx_oe}, 1);
        step_to(k, dly + b / 2);
        chk(!txd, "R2 start bit", txd, 0);
        for (int i = 0; i < n; i++) begin
            step_to(k, dly + b * (1 + i) + b / 2);
            chk(txd == w[i], "R3 data bit", txd, w[i]);
            if (scramble && i == 0) begin
                baud_div    = 16'd7;
                char_len    = 6'd3;
                parity_mode = 2'd2;
                stop_mode   = 2'd0;
                tx_delay    = 16'd9;
            end
        end
        if (p == 1) begin
            step_to(k, dly + b * (1 + n) + b / 2);
            chk(txd == par_bit(w, n, par), "R4 parity bit", txd, par_bit(w, n, par));
        end
        s0   = dly + b * (1 + n + p);
        kend = s0 + stop_ticks(stop) * de;
        step_to(k, kend - 1);
        chk(txd && tx_oe && !tx_done, "R5 last stop cycle",
            {txd, tx_oe, tx_done}, 6);
        step_to(k, kend);
        chk(!tx_oe && txd, "R7 oe drops after stop", tx_oe, 0);
        chk(tx_done == exp_done, "R8 done strobe", tx_done, exp_done);
        if (exp_done) begin
            step_to(k, kend + 1);
            chk(!tx_done, "R8 done width", tx_done, 0);
        end else begin
            chk(q_pop, "R8 next word popped", q_pop, 1);
        end
    endtask

    task automatic one_frame(input logic [31:0] w, input int len, input int par,
                             input int stop, input int div, input int dly);
        @(negedge clk);
        baud_div    = 16'(div);
        char_len    = 6'(len);
        parity_mode = 2'(par);
        stop_mode   = 2'(stop);
        tx_delay    = 16'(dly);
        push(w);
        #1;
        check_frame(w, len, par, stop, div, dly, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and idle state
        chk(txd && !tx_oe && !tx_done && !q_pop, "R1 reset state",
            {txd, tx_oe, tx_done, q_pop}, 8);
        repeat (4) @(negedge clk);
        chk(txd && !tx_oe && !q_pop, "R1 idle with empty queue",
            {txd, tx_oe, q_pop}, 4);

        // Directed corners
        one_frame(32'h0000_00A5, 8, 0, 0, 5, 0);     // R2 default setting
        one_frame(32'h0000_0001, 0, 1, 1, 0, 1);     // R3 size 0, R2 divisor 0
        one_frame(32'hDEAD_BEEF, 40, 2, 3, 1, 3);    // R3 above 32, R5 code 11
        one_frame(32'h0000_0036, 6, 3, 2, 2, 0);     // R4 code 3, R5 two stops
        one_frame(32'hFFFF_FFFF, 32, 1, 1, 1, 20);   // R4 odd, R6 longer delay

        // R8: back-to-back words suppress the first done pulse
        @(negedge clk);
        baud_div = 16'd1; char_len = 6'd5; parity_mode = 2'd2;
        stop_mode = 2'd1; tx_delay = 16'd2;
        push(32'h0000_0013);
        push(32'h0000_000C);
        #1;
        check_frame(32'h0000_0013, 5, 2, 1, 1, 2, 1'b0, 1'b0);
        check_frame(32'h0000_000C, 5, 2, 1, 1, 2, 1'b1, 1'b0);

        // R9: settings changed mid-frame are ignored
        @(negedge clk);
        baud_div = 16'd2; char_len = 6'd10; parity_mode = 2'd1;
        stop_mode = 2'd2; tx_delay = 16'd4;
        push(32'h0000_02C9);
        #1;
        check_frame(32'h0000_02C9, 10, 1, 2, 2, 4, 1'b1, 1'b1);

        // Constrained random frames
        for (int f = 0; f < 28; f++) begin
            one_frame($urandom, 1 + ($urandom % 32), $urandom % 4, $urandom % 4,
                      1 + ($urandom % 2), ($urandom % 3 == 0) ? 0 : $urandom % 13);
        end
        repeat (3) @(negedge clk);
        chk(txd && !tx_oe && !tx_done, "R1 idle at end", {txd, tx_oe, tx_done}, 4);
        report();
    end

endmodule